// File: doc/BRIEF.md
# Operate-Instruction Processor Core

This block is a small 16-bit processor core that runs programs built only from the three operate instructions (add, bitwise and, bitwise invert) and stops when it meets a halt word. It holds its own 256-word instruction memory, an eight-entry register file of 16-bit registers, a program counter, a decoder and a single ALU. Every enabled clock cycle fetches one word, executes it, writes the result and advances the program counter, so one instruction retires per cycle.

Program words enter through a valid/ready load port. The port takes a word in any cycle where `prog_valid` and `prog_ready` are both high. `prog_ready` is high exactly while `run` is low, so a producer must hold its word stable until the core is paused. A word offered while `run` is high is refused and leaves the memory unchanged. Load address `a` holds the word that executes at program address 0x3000 + a. `run`, `halted` and the debug read port are plain control and status pins. The debug port returns any register combinationally.

Top module: `opcore_top`

## Requirements
- R1: After reset `halted` is 0 and all eight registers read 0. The first word executed is the one at load address 0, which is program address 0x3000.
- R2: `prog_ready` equals `not run`. A word is written at `prog_addr` when `prog_valid` and `prog_ready` are both high. A word offered while `run` is high is never written.
- R3: While `run` is 1 and `halted` is 0, one instruction executes per clock and the program counter advances by one. While `run` is 0, registers and program counter hold.
- R4: Opcode bits[15:12] = 0001 is ADD. It writes the sum modulo 2^16 into the register named by bits[11:9], using the register named by bits[8:6] as the first operand. A following instruction sees the new value.
- R5: Opcode 0101 is AND. It writes the bitwise AND of its two operands, with the same field layout as ADD.
- R6: For ADD and AND, bit 5 = 0 takes the second operand from the register named by bits[2:0]. Bit 5 = 1 takes it from bits[4:0], sign-extended as a two's-complement value in -16..15.
- R7: Opcode 1001 is NOT. It writes the bitwise inverse of the register in bits[8:6] into the register in bits[11:9]. Bits[5:0] carry ones.
- R8: Any other opcode writes no register, but the program counter still advances by one.
- R9: The word 0xF025 sets `halted`. After it, nothing further executes and `halted` stays set until reset, even with `run` high.
- R10: `dbg_data` shows the register selected by `dbg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute enable; also blocks loading |
| prog_valid | input | 1 | Load word offered |
| prog_ready | output | 1 | Load word accepted this cycle when high |
| prog_addr | input | 8 | Word index from program base 0x3000 |
| prog_data | input | 16 | Program word |
| halted | output | 1 | Halt word has been executed |
| dbg_sel | input | 3 | Register index for debug read |
| dbg_data | output | 16 | Contents of selected register |

## Verification
The hardest case to reach is a load offered while the core is running. If the refused word landed anyway, it would show up only when the program counter reached that address. The bench starts a counting program and, in the same cycle it raises `run`, drives a different word at an address not yet fetched. It keeps that word offered until halt and then checks that the count matches the original program. A second scenario pauses mid-program, loads a replacement word while paused and resumes, so both sides of the ready rule are exercised on one program.

// File: rtl/opcore_pkg.sv
package opcore_pkg;
  localparam int WORD_W    = 16;
  localparam int REG_NUM   = 8;
  localparam int REG_IDX_W = $clog2(REG_NUM);

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [REG_IDX_W-1:0] ridx_t;

  localparam logic [3:0] OPC_ADD = 4'h1;
  localparam logic [3:0] OPC_AND = 4'h5;
  localparam logic [3:0] OPC_NOT = 4'h9;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_AND  = 2'd1,
    ALU_NOT  = 2'd2,
    ALU_PASS = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    wr_en;
    ridx_t   dst;
    ridx_t   src1;
    ridx_t   src2;
    logic    use_imm;
    word_t   imm;
    alu_op_e op;
    logic    halt;
  } dec_t;
endpackage

// File: rtl/opcore_imem.sv
module opcore_imem
  import opcore_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/opcore_regfile.sv
module opcore_regfile
  import opcore_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  ridx_t waddr,
  input  word_t wdata,
  input  ridx_t ra1,
  output word_t rd1,
  input  ridx_t ra2,
  output word_t rd2,
  input  ridx_t ra3,
  output word_t rd3
);
  word_t rf [REG_NUM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_NUM; i++) rf[i] <= '0;
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  assign rd1 = rf[ra1];
  assign rd2 = rf[ra2];
  assign rd3 = rf[ra3];

  // R4: a write lands in the named register and is visible next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rf[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/opcore_decode.sv
module opcore_decode
  import opcore_pkg::*;
#(
  parameter word_t HALT_WORD = 16'hF025
) (
  input  word_t instr,
  output dec_t  dec
);
  always_comb begin
    dec         = '0;
    dec.dst     = instr[11:9];
    dec.src1    = instr[8:6];
    dec.src2    = instr[2:0];
    dec.use_imm = instr[5];
    dec.imm     = {{(WORD_W-5){instr[4]}}, instr[4:0]};
    dec.op      = ALU_PASS;
    unique case (instr[15:12])
      OPC_ADD: begin dec.wr_en = 1'b1; dec.op = ALU_ADD; end
      OPC_AND: begin dec.wr_en = 1'b1; dec.op = ALU_AND; end
      OPC_NOT: begin dec.wr_en = 1'b1; dec.op = ALU_NOT; dec.use_imm = 1'b0; end
      default: dec.wr_en = 1'b0;
    endcase
    dec.halt = (instr == HALT_WORD);
  end
endmodule

// File: rtl/opcore_alu.sv
module opcore_alu
  import opcore_pkg::*;
(
  input  alu_op_e op,
  input  word_t   a,
  input  word_t   b,
  output word_t   y
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_AND:  y = a & b;
      ALU_NOT:  y = ~a;
      default:  y = a;
    endcase
  end
endmodule

// File: rtl/opcore_top.sv
module opcore_top
  import opcore_pkg::*;
#(
  parameter int    IMEM_DEPTH = 256,
  parameter word_t START_PC   = 16'h3000,
  parameter word_t HALT_WORD  = 16'hF025,
  localparam int   ADDR_W     = $clog2(IMEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [15:0]       prog_data,
  output logic              halted,
  input  logic [2:0]        dbg_sel,
  output logic [15:0]       dbg_data
);
  word_t pc_q;
  logic  halted_q;
  word_t instr;
  dec_t  dec;
  word_t rs1_val, rs2_val, alu_b, alu_y;
  logic  step;
  logic  load_fire;
  logic [ADDR_W-1:0] fetch_idx;

  assign prog_ready = !run;
  assign load_fire  = prog_valid && prog_ready;
  assign fetch_idx  = ADDR_W'(pc_q - START_PC);
  assign step       = run && !halted_q;
  assign halted     = halted_q;

  opcore_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
    .clk   (clk),
    .we    (load_fire),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (fetch_idx),
    .rdata (instr)
  );

  opcore_decode #(.HALT_WORD(HALT_WORD)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  opcore_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (step && dec.wr_en && !dec.halt),
    .waddr (dec.dst),
    .wdata (alu_y),
    .ra1   (dec.src1),
    .rd1   (rs1_val),
    .ra2   (dec.src2),
    .rd2   (rs2_val),
    .ra3   (dbg_sel),
    .rd3   (dbg_data)
  );

  assign alu_b = dec.use_imm ? dec.imm : rs2_val;

  opcore_alu u_alu (
    .op (dec.op),
    .a  (rs1_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= START_PC;
      halted_q <= 1'b0;
    end else if (step) begin
      if (dec.halt) halted_q <= 1'b1;
      else          pc_q     <= pc_q + 16'd1;
    end
  end

  // R9: once halted, only reset clears it and the counter stops
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q && $stable(pc_q));

  // R3: a paused core keeps its program counter
  p_pause_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc_q));

  // R3 / R8: every non-halt word moves the counter by one
  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halted_q && !dec.halt) |=> pc_q == $past(pc_q) + 16'd1);

  // R6: the immediate operand is a sign extension of the literal field
  always_comb begin
    if (rst_n && dec.use_imm && dec.op != ALU_NOT) begin
      p_imm_extend_r6: assert ((&alu_b[15:4] || ~|alu_b[15:4]) && alu_b[3:0] == instr[3:0]);
    end
  end
endmodule

// File: tb/opcore_top_test.sv
module opcore_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic        prog_valid;
  logic        prog_ready;
  logic [7:0]  prog_addr;
  logic [15:0] prog_data;
  logic        halted;
  logic [2:0]  dbg_sel;
  logic [15:0] dbg_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  opcore_top uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .halted(halted), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input int idx);
    return 16'h0;
  endfunction

  task automatic reg_chk(string req, int idx, logic [15:0] exp);
    dbg_sel = 3'(idx);
    #1;
    chk(req, dbg_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; prog_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input int a, input logic [15:0] w);
    prog_valid = 1'b1; prog_addr = 8'(a); prog_data = w;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic run_to_halt(output int cycles);
    cycles = 0;
    run = 1'b1;
    while (cycles < 50) begin
      @(negedge clk);
      cycles++;
      if (halted) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 halted", {15'b0, halted}, 16'h0);
    chk("R2 ready when idle", {15'b0, prog_ready}, 16'h1);
    for (int i = 0; i < 8; i++) reg_chk("R1 reg clear", i, 16'h0);
  endtask

  task automatic t_hundred();
    int cyc;
    do_reset();
    load(0, 16'h54A0);  // AND R2,R2,#0
    load(1, 16'h14AF);  // ADD R2,R2,#15
    load(2, 16'h14AA);  // ADD R2,R2,#10
    load(3, 16'h1482);  // ADD R2,R2,R2
    load(4, 16'h1482);  // ADD R2,R2,R2
    load(5, 16'hF025);  // halt
    run_to_halt(cyc);
    chk("R2 ready low while running", {15'b0, prog_ready}, 16'h0);
    chk("R3 one word per cycle", 16'(cyc), 16'd6);
    chk("R9 halted", {15'b0, halted}, 16'h1);
    reg_chk("R4 R2 = 100", 2, 16'h0064);
    repeat (4) @(negedge clk);
    chk("R9 halt sticky", {15'b0, halted}, 16'h1);
    reg_chk("R9 no execution after halt", 2, 16'h0064);
    reg_chk("R10 untouched reg", 1, 16'h0000);
    run = 1'b0;
  endtask

  task automatic t_mixed();
    int cyc;
    do_reset();
    load(0, 16'h5260);  // AND R1,R1,#0
    load(1, 16'h1276);  // ADD R1,R1,#-10
    load(2, 16'h967F);  // NOT R3,R1
    load(3, 16'h5870);  // AND R4,R1,#-16
    load(4, 16'h1A43);  // ADD R5,R1,R3
    load(5, 16'h5C41);  // AND R6,R1,R1
    load(6, 16'h1F61);  // ADD R7,R5,#1
    load(7, 16'h2E00);  // unsupported opcode
    load(8, 16'h102F);  // ADD R0,R0,#15
    load(9, 16'hF025);
    run_to_halt(cyc);
    chk("R8 cycles incl. no-op", 16'(cyc), 16'd10);
    reg_chk("R6 negative immediate", 1, 16'hFFF6);
    reg_chk("R7 NOT", 3, 16'h0009);
    reg_chk("R5 AND imm -16", 4, 16'hFFF0);
    reg_chk("R4 register add", 5, 16'hFFFF);
    reg_chk("R5 AND same source", 6, 16'hFFF6);
    reg_chk("R4 wrap mod 2^16", 7, 16'h0000);
    reg_chk("R8 no-op then advance", 0, 16'h000F);
    reg_chk("R8 no write R2", 2, 16'h0000);
    run = 1'b0;
  endtask

  task automatic t_pause();
    int cyc;
    do_reset();
    for (int i = 0; i < 4; i++) load(i, 16'h1261);  // ADD R1,R1,#1
    load(4, 16'hF025);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    reg_chk("R3 two steps", 1, 16'h0002);
    load(2, 16'h1265);  // ADD R1,R1,#5, accepted while paused
    @(negedge clk);
    @(negedge clk);
    reg_chk("R3 paused hold", 1, 16'h0002);
    chk("R3 not halted while paused", {15'b0, halted}, 16'h0);
    run_to_halt(cyc);
    reg_chk("R2 load while paused used", 1, 16'h0008);
    run = 1'b0;
  endtask

  task automatic t_load_blocked();
    int cyc;
    do_reset();
    for (int i = 0; i < 3; i++) load(i, 16'h1261);
    load(3, 16'hF025);
    run = 1'b1;
    prog_valid = 1'b1; prog_addr = 8'd2; prog_data = 16'h1267;
    #1;
    chk("R2 ready low under run", {15'b0, prog_ready}, 16'h0);
    cyc = 0;
    while (cyc < 50) begin
      @(negedge clk);
      cyc++;
      if (halted) break;
    end
    prog_valid = 1'b0;
    reg_chk("R2 refused word not written", 1, 16'h0003);
    run = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; prog_valid = 1'b0;
    prog_addr = '0; prog_data = '0; dbg_sel = '0;
    t_reset();
    t_hundred();
    t_mixed();
    t_pause();
    t_load_blocked();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule